// File: doc/BRIEF.md
# Assertion Interestingness Scoring Unit

This unit ranks a small set of mined temporal assertions by how interesting they are. Software or a neighbouring block first writes one entry per assertion through a write port. An entry holds the number of times the assertion was seen to fire and hold on the traces, an identifier for its antecedent and an identifier for its consequent. A start pulse then runs a fixed sequence of passes. For each assertion the unit builds a 2x2 contingency table by summing the counts of the other entries according to whether they share its antecedent, its consequent, or neither. From that table it derives a support value and a correlation coefficient in fixed point. It uses one shared iterative divider and one iterative square-root unit.

When every assertion has its support and correlation, both values are scaled against the largest of their kind in the set. The two scaled values are then mixed with a fixed weight into one score per assertion. The score is written to a result store that can be read at any time through an index port. A busy level covers the whole run. A done level then stays up until the next start.

All values are unsigned Q1.15: 32768 stands for 1.0. Entries keep their contents between runs, so a changed entry can be re-scored by writing only that entry and starting again.

Top module: `asn_score`

## Requirements
- R1: While busy_o is low, a cycle with ld_en_i high writes ld_cnt_i, ld_ant_i and ld_cons_i into entry ld_idx_i. The written values are used by every later run.
- R2: For entry i, f11 is its own count. f10 is the sum of the counts of other entries with the same antecedent and a different consequent. f01 is the sum of the counts of other entries with the same consequent and a different antecedent. f00 is the grand total minus f11, f10 and f01, so an entry with both identifiers equal to those of i lands in f00.
- R3: Support is floor(f11·2^15 / T), where T is the sum of all counts. It is 0 when T is 0.
- R4: Let P be (f11+f10)(f01+f00)(f11+f01)(f10+f00) and D = floor(sqrt(P)). Correlation is floor((f11·f00 − f10·f01)·2^15 / D), capped at 32768. It is 0 when the numerator is not positive or D is 0.
- R5: The normalized support is floor(s·2^15 / max s) over all entries. The normalized correlation is floor(c·2^15 / max c). Each is 0 when its maximum is 0.
- R6: The score is floor((A·ns + (32768−A)·nc) / 2^15) with A = 13107 (0.4). No score exceeds 32768. rd_score_o shows the score of entry rd_idx_i without delay.
- R7: A start_i accepted while idle raises busy_o and clears done_o in the next cycle. busy_o then stays high until the cycle in which done_o rises. done_o and busy_o are never high together. done_o holds until the next start.
- R8: A load request while busy_o is high changes no entry, in the current run or in later ones.
- R9: A start_i while busy_o is high has no effect: the run ends in the same cycle and with the same scores as without it.
- R10: A load and a start in the same idle cycle are both taken, and that run already uses the newly written entry.
- R11: After reset, busy_o and done_o are low and every score reads 0.
- R12: With all counts 0, every score is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Entry write request |
| ld_idx_i | input | IDX_W (3) | Entry written |
| ld_cnt_i | input | CNT_W (12) | Occurrence count |
| ld_ant_i | input | ID_W (4) | Antecedent identifier |
| ld_cons_i | input | ID_W (4) | Consequent identifier |
| start_i | input | 1 | Start pulse for a scoring run |
| rd_idx_i | input | IDX_W (3) | Score read index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Scores valid since last run |
| rd_score_o | output | 16 | Q1.15 score of entry rd_idx_i |

## Verification
Two events can meet in one cycle: an entry write and a start, and each can also coincide with a run already in progress. The bench provokes all three combinations. It issues a write together with a start from idle and expects scores that reflect the new entry. It writes an entry in the middle of a run and expects the scores, and those of a repeat run, to match the unchanged table. It pulses start in the middle of a run and expects the same cycle count to done and the same scores as a clean run.

// File: rtl/asn_score_pkg.sv
package asn_score_pkg;

  // Fraction bits of the Q1.15 values and the fixed-point one.
  localparam int unsigned FRAC_W = 15;
  localparam int unsigned ONE_Q  = 32768;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TOTAL,   // grand total over all entries
    ST_CELL,    // cross-sum for entry i
    ST_PREP,    // numerator and root launch
    ST_ROOT,    // wait for square root, launch support divide
    ST_SUPDIV,  // wait support, launch correlation divide
    ST_CORDIV,  // wait correlation
    ST_NSUP,    // wait normalized support
    ST_NCOR     // wait normalized correlation, write score
  } scan_state_e;

endpackage

// File: rtl/asn_score_div.sv
// Iterative restoring divider, one quotient bit per cycle.
module asn_score_div #(
  parameter int unsigned NUM_W = 45,
  parameter int unsigned DEN_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);

  localparam int unsigned STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]    rem_q, rem_d;
  logic [NUM_W-1:0]  quo_q, quo_d;
  logic [DEN_W-1:0]  den_q, den_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic [DEN_W:0]    shifted;
  logic [DEN_W+1:0]  diff;

  always_comb begin
    shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    diff    = {1'b0, shifted} - {2'b00, den_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    step_d  = step_q;
    done_d  = 1'b0;
    if (go_i) begin
      rem_d  = '0;
      quo_d  = num_i;
      den_d  = den_i;
      step_d = STEP_W'(NUM_W);
    end else if (step_q != '0) begin
      if (!diff[DEN_W+1]) begin
        rem_d = diff[DEN_W:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = shifted;
        quo_d = {quo_q[NUM_W-2:0], 1'b0};
      end
      step_d = step_q - 1'b1;
      done_d = (step_q == STEP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;

endmodule

// File: rtl/asn_score_isqrt.sv
// Iterative integer square root, one result bit per cycle.
module asn_score_isqrt #(
  parameter int unsigned ROOT_W = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [2*ROOT_W-1:0] rad_i,
  output logic [ROOT_W-1:0]   root_o,
  output logic                done_o
);

  localparam int unsigned RAD_W  = 2 * ROOT_W;
  localparam int unsigned STEP_W = $clog2(ROOT_W + 1);

  logic [RAD_W-1:0]  op_q, op_d, res_q, res_d, bit_q, bit_d, trial;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;

  always_comb begin
    trial  = res_q + bit_q;
    op_d   = op_q;
    res_d  = res_q;
    bit_d  = bit_q;
    step_d = step_q;
    done_d = 1'b0;
    if (go_i) begin
      op_d   = rad_i;
      res_d  = '0;
      bit_d  = {2'b01, {(RAD_W-2){1'b0}}};
      step_d = STEP_W'(ROOT_W);
    end else if (step_q != '0) begin
      if (op_q >= trial) begin
        op_d  = op_q - trial;
        res_d = (res_q >> 1) + bit_q;
      end else begin
        res_d = res_q >> 1;
      end
      bit_d  = bit_q >> 2;
      step_d = step_q - 1'b1;
      done_d = (step_q == STEP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      res_q  <= res_d;
      bit_q  <= bit_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign root_o = res_q[ROOT_W-1:0];
  assign done_o = done_q;

endmodule

// File: rtl/asn_score.sv
module asn_score
  import asn_score_pkg::*;
#(
  parameter int unsigned N_ASRT  = 8,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned ALPHA_Q = 13107,
  localparam int unsigned IDX_W  = $clog2(N_ASRT),
  localparam int unsigned VAL_W  = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [CNT_W-1:0] ld_cnt_i,
  input  logic [ID_W-1:0]  ld_ant_i,
  input  logic [ID_W-1:0]  ld_cons_i,
  input  logic             start_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [VAL_W-1:0] rd_score_o
);

  localparam int unsigned SUM_W   = CNT_W + IDX_W;
  localparam int unsigned PROD_W  = 4 * SUM_W;
  localparam int unsigned ROOT_W  = 2 * SUM_W;
  localparam int unsigned NUM_W   = 2 * SUM_W;
  localparam int unsigned QN_W    = NUM_W + FRAC_W;
  localparam int unsigned BLEND_W = 2 * VAL_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ASRT - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  // entry table and result stores
  logic [N_ASRT-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [N_ASRT-1:0][ID_W-1:0]  ant_q, ant_d, cons_q, cons_d;
  logic [N_ASRT-1:0][VAL_W-1:0] sup_q, sup_d, cor_q, cor_d, score_q, score_d;

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] i_q, i_d, j_q, j_d;
  logic [SUM_W-1:0] tot_q, tot_d, f10_q, f10_d, f01_q, f01_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic             pos_q, pos_d;
  logic [ROOT_W-1:0] root_q, root_d;
  logic [VAL_W-1:0] maxs_q, maxs_d, maxc_q, maxc_d, ns_q, ns_d;
  logic             busy_q, busy_d, done_q, done_d;

  // contingency cells of entry i_q
  logic [SUM_W-1:0]  f11, f00, f1x, f0x, fx1, fx0;
  logic [PROD_W-1:0] prod_c;
  logic [NUM_W-1:0]  pa, pb;
  logic              same_a, same_c;

  assign f11    = SUM_W'(cnt_q[i_q]);
  assign f00    = tot_q - f11 - f10_q - f01_q;
  assign f1x    = f11 + f10_q;
  assign f0x    = f01_q + f00;
  assign fx1    = f11 + f01_q;
  assign fx0    = f10_q + f00;
  assign prod_c = PROD_W'(f1x) * PROD_W'(f0x) * PROD_W'(fx1) * PROD_W'(fx0);
  assign pa     = NUM_W'(f11) * NUM_W'(f00);
  assign pb     = NUM_W'(f10_q) * NUM_W'(f01_q);
  assign same_a = (ant_q[j_q] == ant_q[i_q]);
  assign same_c = (cons_q[j_q] == cons_q[i_q]);

  // shared arithmetic units
  logic              sq_go, sq_done, div_go, div_done;
  logic [ROOT_W-1:0] sq_root;
  logic [QN_W-1:0]   div_num, div_quo;
  logic [ROOT_W-1:0] div_den;

  asn_score_isqrt #(.ROOT_W(ROOT_W)) u_isqrt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go_i   (sq_go),
    .rad_i  (prod_c),
    .root_o (sq_root),
    .done_o (sq_done)
  );

  asn_score_div #(.NUM_W(QN_W), .DEN_W(ROOT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .quo_o  (div_quo),
    .done_o (div_done)
  );

  logic [VAL_W-1:0]   sup_v, cor_v, nc_v;
  logic [BLEND_W-1:0] blend_v;

  always_comb begin
    sup_v   = (tot_q == '0) ? '0 : div_quo[VAL_W-1:0];
    cor_v   = (!pos_q || root_q == '0) ? '0 :
              (div_quo > QN_W'(ONE_Q)) ? VAL_W'(ONE_Q) : div_quo[VAL_W-1:0];
    nc_v    = (maxc_q == '0) ? '0 : div_quo[VAL_W-1:0];
    blend_v = (BLEND_W'(ALPHA_Q) * BLEND_W'(ns_q)
             + BLEND_W'(ONE_Q - ALPHA_Q) * BLEND_W'(nc_v)) >> FRAC_W;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;  i_d = i_q;  j_d = j_q;
    tot_d = tot_q;  f10_d = f10_q;  f01_d = f01_q;
    num_d = num_q;  pos_d = pos_q;  root_d = root_q;
    maxs_d = maxs_q;  maxc_d = maxc_q;  ns_d = ns_q;
    busy_d = busy_q;  done_d = done_q;
    cnt_d = cnt_q;  ant_d = ant_q;  cons_d = cons_q;
    sup_d = sup_q;  cor_d = cor_q;  score_d = score_q;
    sq_go = 1'b0;  div_go = 1'b0;  div_num = '0;  div_den = '0;

    if (ld_en_i && !busy_q) begin
      cnt_d[ld_idx_i]  = ld_cnt_i;
      ant_d[ld_idx_i]  = ld_ant_i;
      cons_d[ld_idx_i] = ld_cons_i;
    end

    unique case (state_q)
      ST_IDLE: if (start_i) begin
        busy_d = 1'b1;  done_d = 1'b0;
        tot_d = '0;  j_d = '0;  maxs_d = '0;  maxc_d = '0;
        state_d = ST_TOTAL;
      end
      ST_TOTAL: begin
        tot_d = tot_q + SUM_W'(cnt_q[j_q]);
        j_d   = j_q + 1'b1;
        if (j_q == LAST_IDX) begin
          i_d = '0;  j_d = '0;  f10_d = '0;  f01_d = '0;
          state_d = ST_CELL;
        end
      end
      ST_CELL: begin
        if (j_q != i_q) begin
          if (same_a && !same_c) f10_d = f10_q + SUM_W'(cnt_q[j_q]);
          if (same_c && !same_a) f01_d = f01_q + SUM_W'(cnt_q[j_q]);
        end
        j_d = j_q + 1'b1;
        if (j_q == LAST_IDX) state_d = ST_PREP;
      end
      ST_PREP: begin
        sq_go = 1'b1;
        pos_d = (pa > pb);
        num_d = pa - pb;
        state_d = ST_ROOT;
      end
      ST_ROOT: if (sq_done) begin
        root_d  = sq_root;
        div_go  = 1'b1;
        div_num = QN_W'(f11) << FRAC_W;
        div_den = ROOT_W'(tot_q);
        state_d = ST_SUPDIV;
      end
      ST_SUPDIV: if (div_done) begin
        sup_d[i_q] = sup_v;
        if (sup_v > maxs_q) maxs_d = sup_v;
        div_go  = 1'b1;
        div_num = QN_W'(num_q) << FRAC_W;
        div_den = root_q;
        state_d = ST_CORDIV;
      end
      ST_CORDIV: if (div_done) begin
        cor_d[i_q] = cor_v;
        if (cor_v > maxc_q) maxc_d = cor_v;
        if (i_q == LAST_IDX) begin
          i_d     = '0;
          div_go  = 1'b1;
          div_num = QN_W'(sup_q[0]) << FRAC_W;
          div_den = ROOT_W'(maxs_q);
          state_d = ST_NSUP;
        end else begin
          i_d = i_q + 1'b1;  j_d = '0;  f10_d = '0;  f01_d = '0;
          state_d = ST_CELL;
        end
      end
      ST_NSUP: if (div_done) begin
        ns_d    = (maxs_q == '0) ? '0 : div_quo[VAL_W-1:0];
        div_go  = 1'b1;
        div_num = QN_W'(cor_q[i_q]) << FRAC_W;
        div_den = ROOT_W'(maxc_q);
        state_d = ST_NCOR;
      end
      ST_NCOR: if (div_done) begin
        score_d[i_q] = blend_v[VAL_W-1:0];
        if (i_q == LAST_IDX) begin
          busy_d = 1'b0;  done_d = 1'b1;
          state_d = ST_IDLE;
        end else begin
          i_d     = i_q + 1'b1;
          div_go  = 1'b1;
          div_num = QN_W'(sup_q[i_q + 1'b1]) << FRAC_W;
          div_den = ROOT_W'(maxs_q);
          state_d = ST_NSUP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      i_q <= '0;  j_q <= '0;
      tot_q <= '0;  f10_q <= '0;  f01_q <= '0;
      num_q <= '0;  pos_q <= 1'b0;  root_q <= '0;
      maxs_q <= '0;  maxc_q <= '0;  ns_q <= '0;
      busy_q <= 1'b0;  done_q <= 1'b0;
      cnt_q <= '0;  ant_q <= '0;  cons_q <= '0;
      sup_q <= '0;  cor_q <= '0;  score_q <= '0;
    end else begin
      state_q <= state_d;
      i_q <= i_d;  j_q <= j_d;
      tot_q <= tot_d;  f10_q <= f10_d;  f01_q <= f01_d;
      num_q <= num_d;  pos_q <= pos_d;  root_q <= root_d;
      maxs_q <= maxs_d;  maxc_q <= maxc_d;  ns_q <= ns_d;
      busy_q <= busy_d;  done_q <= done_d;
      cnt_q <= cnt_d;  ant_q <= ant_d;  cons_q <= cons_d;
      sup_q <= sup_d;  cor_q <= cor_d;  score_q <= score_d;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rd_score_o = score_q[rd_idx_i];

endmodule

// File: rtl/asn_score_chk.sv
module asn_score_chk #(
  parameter int unsigned N_ASRT = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned ID_W   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_i,
  input logic                         busy_o,
  input logic                         done_o,
  input logic [15:0]                  rd_score_o,
  input logic [N_ASRT-1:0][CNT_W-1:0] cnt_q,
  input logic [N_ASRT-1:0][ID_W-1:0]  ant_q,
  input logic [N_ASRT-1:0][ID_W-1:0]  cons_q
);

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  p_start_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  p_table_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(cnt_q) && $stable(ant_q) && $stable(cons_q)));

  p_done_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));

  p_score_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_score_o <= 16'd32768);

endmodule

bind asn_score asn_score_chk #(
  .N_ASRT (N_ASRT),
  .CNT_W  (CNT_W),
  .ID_W   (ID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rd_score_o (rd_score_o),
  .cnt_q      (cnt_q),
  .ant_q      (ant_q),
  .cons_q     (cons_q)
);

// File: tb/asn_score_tb_top.sv
module asn_score_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WAIT_LIMIT = 20000;

  logic        clk, rst_n, ld_en_i, start_i, busy_o, done_o;
  logic [2:0]  ld_idx_i, rd_idx_i;
  logic [11:0] ld_cnt_i;
  logic [3:0]  ld_ant_i, ld_cons_i;
  logic [15:0] rd_score_o;

  int checks = 0;
  int errors = 0;

  longint unsigned m_cnt[N], m_ant[N], m_cons[N], exp_score[N];

  asn_score dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
    .ld_cnt_i(ld_cnt_i), .ld_ant_i(ld_ant_i), .ld_cons_i(ld_cons_i),
    .start_i(start_i), .rd_idx_i(rd_idx_i), .busy_o(busy_o),
    .done_o(done_o), .rd_score_o(rd_score_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input longint act, input longint exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned isqrt(input longint unsigned p);
    longint unsigned r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint unsigned t = r | (64'd1 << b);
      if (t * t <= p) r = t;
    end
    return r;
  endfunction

  // Expected scores straight from the requirement formulas
  function automatic void calc_expected();
    longint unsigned tot = 0, maxs = 0, maxc = 0;
    longint unsigned sup[N], cor[N];
    for (int i = 0; i < N; i++) tot += m_cnt[i];
    for (int i = 0; i < N; i++) begin
      longint unsigned f11 = m_cnt[i], f10 = 0, f01 = 0, f00, p, d, a, b;
      for (int j = 0; j < N; j++) if (j != i) begin
        if (m_ant[j] == m_ant[i] && m_cons[j] != m_cons[i]) f10 += m_cnt[j];
        if (m_cons[j] == m_cons[i] && m_ant[j] != m_ant[i]) f01 += m_cnt[j];
      end
      f00 = tot - f11 - f10 - f01;
      sup[i] = (tot == 0) ? 0 : (f11 << 15) / tot;
      p = (f11 + f10) * (f01 + f00) * (f11 + f01) * (f10 + f00);
      d = isqrt(p);
      a = f11 * f00;
      b = f10 * f01;
      cor[i] = (a > b && d != 0) ? (((a - b) << 15) / d) : 0;
      if (cor[i] > 32768) cor[i] = 32768;
      if (sup[i] > maxs) maxs = sup[i];
      if (cor[i] > maxc) maxc = cor[i];
    end
    for (int i = 0; i < N; i++) begin
      longint unsigned ns = (maxs == 0) ? 0 : (sup[i] << 15) / maxs;
      longint unsigned nc = (maxc == 0) ? 0 : (cor[i] << 15) / maxc;
      exp_score[i] = (13107 * ns + 19661 * nc) >> 15;
    end
  endfunction

  task automatic load_entry(input int idx, input int cnt, input int ant, input int cons);
    @(negedge clk);
    ld_en_i = 1'b1; ld_idx_i = 3'(idx); ld_cnt_i = 12'(cnt);
    ld_ant_i = 4'(ant); ld_cons_i = 4'(cons);
    @(negedge clk);
    ld_en_i = 1'b0;
    m_cnt[idx] = cnt; m_ant[idx] = ant; m_cons[idx] = cons;
  endtask

  task automatic pulse_start(input string req);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, 1, req, "busy after start");
    check(done_o, 0, req, "done cleared by start");
  endtask

  task automatic wait_done(output int cycles);
    cycles = 1;
    while (!done_o && cycles < WAIT_LIMIT) begin
      @(negedge clk);
      cycles++;
    end
    if (!done_o) begin
      checks++; errors++;
      $display("FAIL watchdog: done not seen within %0d cycles", WAIT_LIMIT);
    end
  endtask

  task automatic check_scores(input string req);
    calc_expected();
    check(busy_o, 0, "R7", "busy low at done");
    for (int i = 0; i < N; i++) begin
      rd_idx_i = 3'(i);
      #1;
      check(rd_score_o, exp_score[i], req, $sformatf("score[%0d]", i));
    end
  endtask

  task automatic run_check(input string req, output int cycles);
    pulse_start("R7");
    wait_done(cycles);
    check_scores(req);
  endtask

  task automatic t_reset();
    check(busy_o, 0, "R11", "busy after reset");
    check(done_o, 0, "R11", "done after reset");
    for (int i = 0; i < N; i++) begin
      rd_idx_i = 3'(i);
      #1;
      check(rd_score_o, 0, "R11", $sformatf("reset score[%0d]", i));
    end
  endtask

  // mixed set: four lone rules plus three sharing antecedent 5
  // (entry 4 then has f10 = 516 + 509 = 1025)
  task automatic t_mixed();
    int c;
    load_entry(0, 468, 1, 1); load_entry(1, 436, 2, 2);
    load_entry(2, 481, 3, 3); load_entry(3, 361, 4, 4);
    load_entry(4, 524, 5, 9); load_entry(5, 516, 5, 10);
    load_entry(6, 509, 5, 11); load_entry(7, 0, 0, 0);
    run_check("R1 R2 R3 R4 R5 R6", c);
  endtask

  // entry 7 duplicates entry 4's identifiers: it counts in f00
  task automatic t_duplicate();
    int c;
    load_entry(7, 300, 5, 9);
    load_entry(3, 200, 4, 10);
    run_check("R2", c);
  endtask

  task automatic t_negative();
    int c;
    for (int i = 0; i < N; i++) load_entry(i, 0, 12, i);
    load_entry(0, 10, 1, 1);
    load_entry(1, 900, 1, 2);
    load_entry(2, 900, 3, 1);
    load_entry(3, 50, 7, 7);
    run_check("R4 R5", c);
  endtask

  task automatic t_single();
    int c;
    for (int i = 0; i < N; i++) load_entry(i, 0, i, i);
    load_entry(2, 777, 2, 2);
    run_check("R4 R5", c);
    rd_idx_i = 3'd2;
    #1;
    check(rd_score_o, 13107, "R4", "lone entry, zero root denominator");
  endtask

  task automatic t_all_zero();
    int c;
    for (int i = 0; i < N; i++) load_entry(i, 0, 1, 1);
    run_check("R12 R3", c);
  endtask

  task automatic t_load_busy();
    int c;
    t_mixed();
    pulse_start("R7");
    repeat (20) @(negedge clk);
    ld_en_i = 1'b1; ld_idx_i = 3'd0; ld_cnt_i = 12'd4000;
    ld_ant_i = 4'd5; ld_cons_i = 4'd9;
    @(negedge clk);
    ld_en_i = 1'b0;
    wait_done(c);
    check_scores("R8");
    run_check("R8", c);
  endtask

  task automatic t_start_busy();
    int c_ref, c_dbl;
    run_check("R9", c_ref);
    pulse_start("R7");
    repeat (100) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(c_dbl);
    c_dbl += 101;
    check(c_dbl, c_ref, "R9", "cycles to done with extra start");
    check_scores("R9");
  endtask

  task automatic t_load_start();
    int c;
    @(negedge clk);
    ld_en_i = 1'b1; ld_idx_i = 3'd1; ld_cnt_i = 12'd2500;
    ld_ant_i = 4'd5; ld_cons_i = 4'd12;
    start_i = 1'b1;
    @(negedge clk);
    ld_en_i = 1'b0; start_i = 1'b0;
    m_cnt[1] = 2500; m_ant[1] = 5; m_cons[1] = 12;
    check(busy_o, 1, "R10", "busy after joint load and start");
    wait_done(c);
    check_scores("R10");
  endtask

  initial begin
    rst_n = 1'b0; ld_en_i = 1'b0; start_i = 1'b0;
    ld_idx_i = '0; ld_cnt_i = '0; ld_ant_i = '0; ld_cons_i = '0; rd_idx_i = '0;
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = 0; m_ant[i] = 0; m_cons[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mixed();
    t_duplicate();
    t_negative();
    t_single();
    t_all_zero();
    t_load_busy();
    t_start_busy();
    t_load_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule